// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-line general-purpose I/O port behind a small memory-mapped register bus. Each line has a direction bit. A line set as an output drives its pad from an output latch and raises that pad's output enable. A line set as an input is read from its pad through a two-flop synchroniser.

Pin data sits in a window of the address space. In that window, address bits [9:2] form a per-pin mask. A single byte access touches only the pins whose mask bit is set, so software can set, clear or sample any subset of pins in one bus cycle. There is no read-modify-write sequence and no race between agents that share the port. Writes to the output latch take effect only on pins that are currently outputs. Software must therefore switch a pin to output before it gives the pin its value.

Bus accesses last one cycle and are byte wide and word aligned. Read data appears on the cycle after the request.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction register and the output latch are all zero, `pad_oe_o` and `pad_out_o` are 0, and `rdata_o` is 0.
- R2: A write at byte offset 0x400 loads the direction register. Bit n = 1 makes pin n an output. `pad_oe_o` equals the direction register from the cycle after the write.
- R3: A write in the data window (offsets 0x000–0x3FC) copies `wdata_i[n]` into latch bit n only when address bit n+2 is 1 and pin n is an output. Every other latch bit keeps its value.
- R4: A data-window write to a pin configured as input leaves that pin's latch bit unchanged. The old value appears on the pad when the pin is later made an output.
- R5: `pad_out_o[n]` equals latch bit n while pin n is an output, and is 0 while pin n is an input.
- R6: A data-window read returns the pin value in the bit positions whose address bit n+2 is 1, and 0 in all other positions. `rdata_o` carries the result in the cycle after the request and is 0 in any cycle that follows no read.
- R7: An input pin is read through two flops. A pad change made just before clock edge k is returned by a read sampled at edge k+2, and not by reads sampled at edges k or k+1.
- R8: An output pin reads back its latch value, not the pad level.
- R9: A read at offset 0x400 returns the direction register.
- R10: A read from an unmapped offset (anything other than the data window and 0x400) returns 0. A write there changes no state.
- R11: Address bits [1:0] are ignored for decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read request |
| pad_in_i | input | 8 | Pad input levels (asynchronous) |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The masked window is tried in three ways: with a full mask, with single-bit and sparse masks, and with an empty mask. The full mask shows the basic data path. The sparse masks show that unselected pins hold their value and read as zero. The empty mask shows that an access with no pins selected does nothing. Writes are issued while pins are inputs, and the same pins are then switched to output. This separates a latch that gates writes by direction from one that takes every write. Pad levels change right before a string of reads, which pins down the two-cycle synchroniser delay. Accesses to nearby unmapped offsets and to addresses with the low two bits set test the exactness of the decode.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
  import gpio_mp_pkg::*;
#(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DIR_OFF = 'h400
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [NPIN-1:0]   mask_o
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = NPIN + MASK_LO - 1;
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFF >> 2);

  logic data_hit, dir_hit;

  assign data_hit = (addr_i[ADDR_W-1:MASK_HI+1] == '0);
  assign dir_hit  = (addr_i[ADDR_W-1:2] == DIR_WORD);
  assign mask_o   = addr_i[MASK_HI:MASK_LO];

  always_comb begin
    if (data_hit)     kind_o = ACC_DATA;
    else if (dir_hit) kind_o = ACC_DIR;
    else              kind_o = ACC_NONE;
  end
endmodule

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] async_i,
  output logic [NPIN-1:0] sync_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[p]};
    end
    assign sync_o[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_dir_i,
  input  logic            wr_data_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] out_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_bit
    logic dir_q, out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dir_q <= 1'b0;
      else if (wr_dir_i) dir_q <= wdata_i[p];
    end
    // latch only accepts data for selected pins already in output mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                out_q <= 1'b0;
      else if (wr_data_i && mask_i[p] && dir_q)   out_q <= wdata_i[p];
    end
    assign dir_o[p] = dir_q;
    assign out_o[p] = out_q;
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mp_pkg::*;
#(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DIR_OFF = 'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o
);
  acc_kind_e       kind;
  logic [NPIN-1:0] mask, dir_q, out_q, in_sync, pin_val;
  logic [NPIN-1:0] rdata_d, rdata_q;
  logic            wr_dir, wr_data, rd;

  gpio_mp_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_decode (
    .addr_i (addr_i),
    .kind_o (kind),
    .mask_o (mask)
  );

  assign wr_dir  = req_i && we_i && (kind == ACC_DIR);
  assign wr_data = req_i && we_i && (kind == ACC_DATA);
  assign rd      = req_i && !we_i;

  gpio_mp_regs #(.NPIN(NPIN)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_dir_i  (wr_dir),
    .wr_data_i (wr_data),
    .mask_i    (mask),
    .wdata_i   (wdata_i),
    .dir_o     (dir_q),
    .out_o     (out_q)
  );

  gpio_mp_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (in_sync)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_val
    assign pin_val[p] = dir_q[p] ? out_q[p] : in_sync[p];
  end

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      unique case (kind)
        ACC_DATA: rdata_d = pin_val & mask;
        ACC_DIR:  rdata_d = dir_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign pad_oe_o  = dir_q;
  assign pad_out_o = out_q & dir_q;
endmodule

// File: rtl/gpio_mp_chk.sv
module gpio_mp_chk #(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DIR_OFF = 'h400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPIN-1:0]   wdata_i,
  input logic [NPIN-1:0]   rdata_o,
  input logic [NPIN-1:0]   pad_out_o,
  input logic [NPIN-1:0]   pad_oe_o
);
  localparam int unsigned MHI = NPIN + 1;
  logic in_data, in_dir, unmapped;
  assign in_data  = (addr_i[ADDR_W-1:MHI+1] == '0);
  assign in_dir   = (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(DIR_OFF >> 2));
  assign unmapped = !in_data && !in_dir;

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_dir |=> pad_oe_o == $past(wdata_i));

  // R5
  out_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  // R6
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  // R6
  rdata_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && in_data |=> (rdata_o & ~$past(addr_i[MHI:2])) == '0);

  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && unmapped |=> $stable(pad_oe_o) && $stable(pad_out_o));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && unmapped |=> rdata_o == '0);

  // R3
  data_wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_data |=> $stable(pad_oe_o));
endmodule

bind gpio_masked_port gpio_mp_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o)
);

// File: tb/gpio_masked_port_bench.sv
module gpio_masked_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, pad_in = '0;
  logic [7:0]  rdata, pad_out, pad_oe;

  int tests = 0, fails = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_masked_port u_gpio_masked_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // behavioural reference model
  logic [7:0] m_dir, m_out, m_s1, m_s2, m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
    end else begin
      automatic int unsigned a = addr;
      automatic bit is_data = (a < 'h400);
      automatic bit is_dir  = ((a >> 2) == ('h400 >> 2));
      automatic logic [7:0] nrd = 0;
      automatic logic [7:0] nout = m_out;
      for (int i = 0; i < 8; i++) begin
        automatic bit sel = a[i+2];
        if (req && !we && is_data && sel)
          nrd[i] = m_dir[i] ? m_out[i] : m_s2[i];
        if (req && we && is_data && sel && m_dir[i])
          nout[i] = wdata[i];
      end
      if (req && !we && is_dir) nrd = m_dir;
      if (req && we && is_dir) m_dir <= wdata;
      m_out <= nout;
      m_rd  <= nrd;
      m_s1  <= pad_in;
      m_s2  <= m_s1;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({phase, " rdata model"}, rdata, m_rd);
    check("R2 oe model", pad_oe, m_dir);
    check("R5 out model", pad_out, m_out & m_dir);
  end

  // tasks start and end at a falling edge
  task automatic wr(logic [11:0] a, logic [7:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd(12'h400, v); check("R1 dir", v, 8'h00);

    phase = "R2";
    wr(12'h400, 8'h0F);
    check("R2 oe", pad_oe, 8'h0F);
    phase = "R9";
    rd(12'h400, v); check("R9 dir read", v, 8'h0F);

    phase = "R3";
    wr(12'h3FC, 8'hFF);
    check("R3 full mask", pad_out, 8'h0F);
    wr(12'h014, 8'h00);
    check("R3 sparse mask", pad_out, 8'h0A);
    wr(12'h000, 8'hFF);
    check("R3 empty mask", pad_out, 8'h0A);

    phase = "R4";
    wr(12'h400, 8'hFF);
    check("R4 input write held", pad_out, 8'h0A);
    wr(12'h3C0, 8'hF0);
    check("R3 upper nibble", pad_out, 8'hFA);

    phase = "R5";
    wr(12'h400, 8'h0F);
    check("R5 gated", pad_out, 8'h0A);

    phase = "R8";
    pad_in = 8'h55;
    repeat (3) @(negedge clk);
    rd(12'h3FC, v); check("R8 mixed read", v, 8'h5A);

    phase = "R6";
    rd(12'h048, v); check("R6 masked read", v, 8'h12);
    rd(12'h000, v); check("R6 empty mask read", v, 8'h00);
    @(negedge clk);
    check("R6 idle zero", rdata, 8'h00);

    phase = "R7";
    pad_in = 8'hA5;
    rd(12'h3FC, v); check("R7 edge k", v, 8'h5A);
    rd(12'h3FC, v); check("R7 edge k+1", v, 8'h5A);
    rd(12'h3FC, v); check("R7 edge k+2", v, 8'hAA);

    phase = "R10";
    wr(12'h404, 8'hFF);
    check("R10 oe unchanged", pad_oe, 8'h0F);
    rd(12'h404, v); check("R10 read 404", v, 8'h00);
    rd(12'h800, v); check("R10 read 800", v, 8'h00);
    wr(12'hBFC, 8'h00);
    check("R10 out unchanged", pad_out, 8'h0A);

    phase = "R11";
    rd(12'h403, v); check("R11 dir low bits", v, 8'h0F);
    wr(12'h3FF, 8'h00);
    check("R11 data low bits", pad_out, 8'h00);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule